// File: doc/BRIEF.md
# Synchronous Byte-Writable SRAM Core with Selectable Read Latency

This block is a single-port synchronous static memory, 32 bits wide and split into four byte lanes. Every synchronous input (word address, write data, the three chip selects, the write controls and the power-down request) is captured in an input register on the rising clock edge. A write takes effect at the next edge, which makes the write self-timed. Bytes are chosen either through a global write strobe, which writes the whole word, or through a byte-write strobe together with four per-lane enables. The word address comes from an external burst or address generator.

Read latency is chosen at run time. In flow-through mode the read word appears in the cycle right after the edge that captured the read. In pipelined mode an extra output register delays it by one more cycle. Because a write reaches the array at the edge that captures the following cycle, a read issued right after a write to the same word returns the new data. With a partial byte mask, that data is the new bytes merged with the old ones. An asynchronous output-enable and a power-down input gate the output. High impedance is modelled as a low valid flag with the data bus forced to zero.

Top module: `sync_sram_core`

## Requirements
- R1: After reset, before any access, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: When `gwr_n` is 0 in a started cycle, all four bytes of the addressed word are written with `wr_data`, whatever `bwr_n` and `lane_n` hold.
- R3: When `gwr_n` is 1 and `bwr_n` is 0, only the lanes whose `lane_n` bit is 0 are written, where bit i selects `wr_data[8i+7:8i]`. The other lanes keep their old contents. If both strobes are 1, or no lane bit is 0, the cycle is a read and nothing is written.
- R4: A cycle starts only when, at the rising edge, `sel_a_n` is 0, `sel_b` is 1, `sel_c_n` is 0 and `sleep` is 0. If any of these fails, nothing is written and no read data is produced.
- R5: With `pipe_mode` at 0, a read captured at edge k drives the addressed word on `rd_data`, with `rd_valid` at 1, from edge k until edge k+1.
- R6: With `pipe_mode` at 1, a read captured at edge k drives its word, with `rd_valid` at 1, from edge k+1 until edge k+2. Between edge k and edge k+1 the output reflects the cycle before.
- R7: A read captured at the edge right after a write to the same address returns the written bytes merged with the unwritten old bytes, in both latency modes.
- R8: While `out_en_n` is 1, `rd_valid` is 0 and `rd_data` is zero. This takes effect at once, without a clock edge, and lowering `out_en_n` restores the pending word.
- R9: While `sleep` is 1, `rd_valid` is 0 without waiting for a clock edge, and a write presented while `sleep` is 1 does not change memory.
- R10: After a deselect cycle is captured at edge k, the output turns off after edge k in flow-through mode and after edge k+1 in pipelined mode. Each is one cycle after the last read's data appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write strobe, active low, all lanes |
| bwr_n | input | 1 | Byte-write strobe, active low, qualifies `lane_n` |
| lane_n | input | DATA_W/8 | Per-lane write enables, active low |
| pipe_mode | input | 1 | 1 selects pipelined reads, 0 selects flow-through |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| rd_data | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | Output driven; low stands for high impedance |

## Verification
Each result has its own due cycle. Flow-through read data is due just after the edge that captures the read. Pipelined data is due one edge later. A write becomes visible to a read captured at the next edge. The output-enable and power-down gates act with no edge at all. The bench drives and samples 1 ns after each rising edge and counts the edges in every task. It therefore checks the flow-through word after one edge and the pipelined word after two. It checks that the pipelined output still shows the previous cycle after the first edge. It toggles the asynchronous gates between edges and samples again within the same cycle.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_core_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              sleep,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [NLANE-1:0]  lane_n,
  output cmd_e              cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [NLANE-1:0]  mask_q
);

  logic             start_d;
  logic [NLANE-1:0] mask_d;
  cmd_e             cmd_d;

  // Next-state decode of the sampled controls
  always_comb begin
    start_d = !sel_a_n && sel_b && !sel_c_n && !sleep;
    if (!gwr_n) begin
      mask_d = '1;
    end else if (!bwr_n) begin
      mask_d = ~lane_n;
    end else begin
      mask_d = '0;
    end
    if (!start_d) begin
      cmd_d = CMD_IDLE;
    end else if (|mask_d) begin
      cmd_d = CMD_WRITE;
    end else begin
      cmd_d = CMD_READ;
    end
  end

  // Command register, always loaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_IDLE;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  // Operand registers, loaded only when a cycle starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (start_d) begin
      addr_q <= addr;
      data_q <= wr_data;
      mask_q <= mask_d;
    end
  end

  // R2: global strobe in a started cycle writes every lane
  a_r2_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && sel_b && !sel_c_n && !sleep && !gwr_n)
      |=> (cmd_q == CMD_WRITE && mask_q == '1));

  // R4: any select inactive or sleep blocks the cycle
  a_r4_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n || !sel_b || sel_c_n || sleep) |=> (cmd_q == CMD_IDLE));

endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_core_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANE = DATA_W / LANE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NLANE-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_word
);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    always_comb begin
      lane_we = wr_en && wr_mask[g];
    end

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[acc_addr] <= wr_word[g*LANE_W +: LANE_W];
      end
    end

    always_comb begin
      rd_word[g*LANE_W +: LANE_W] = lane_mem[acc_addr];
    end
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic              rd_act,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic              pl_valid_q;
  logic [DATA_W-1:0] pl_data_q;
  logic              src_valid;
  logic [DATA_W-1:0] src_data;

  // Pipeline output register, data loaded only on reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_valid_q <= 1'b0;
    end else begin
      pl_valid_q <= rd_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_data_q <= '0;
    end else if (rd_act) begin
      pl_data_q <= arr_word;
    end
  end

  // Latency select and asynchronous gating
  always_comb begin
    if (pipe_mode) begin
      src_valid = pl_valid_q;
      src_data  = pl_data_q;
    end else begin
      src_valid = rd_act;
      src_data  = arr_word;
    end
    rd_valid = src_valid && !out_en_n && !sleep;
    rd_data  = rd_valid ? src_data : '0;
  end

  // R8: output enable high means no drive and a zero bus
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rd_valid && rd_data == '0));

  // R9: power-down turns the output off
  a_r9_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_valid);

  // R6: pipelined read data due one edge after the read is active
  a_r6_pipe_due: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> (!pipe_mode || out_en_n || sleep || rd_valid));

  // R10: in pipelined mode, output off one edge after a non-read cycle
  a_r10_pipe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> (!pipe_mode || !rd_valid));

endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
  import sram_core_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [NLANE-1:0]  lane_n,
  input  logic              pipe_mode,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [NLANE-1:0]  mask_q;
  logic [DATA_W-1:0] arr_word;
  logic              wr_act;
  logic              rd_act;

  sram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_data (wr_data),
    .sel_a_n (sel_a_n),
    .sel_b   (sel_b),
    .sel_c_n (sel_c_n),
    .sleep   (sleep),
    .gwr_n   (gwr_n),
    .bwr_n   (bwr_n),
    .lane_n  (lane_n),
    .cmd_q   (cmd_q),
    .addr_q  (addr_q),
    .data_q  (data_q),
    .mask_q  (mask_q)
  );

  always_comb begin
    wr_act = (cmd_q == CMD_WRITE);
    rd_act = (cmd_q == CMD_READ);
  end

  // The write commits at the edge ending its cycle, so a read captured
  // at that same edge sees the merged word (pass-through).
  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .wr_en    (wr_act),
    .acc_addr (addr_q),
    .wr_mask  (mask_q),
    .wr_word  (data_q),
    .rd_word  (arr_word)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .out_en_n  (out_en_n),
    .sleep     (sleep),
    .rd_act    (rd_act),
    .arr_word  (arr_word),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R5: in flow-through mode a read cycle drives the output at once
  a_r5_flow_due: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !pipe_mode && !out_en_n && !sleep) |-> rd_valid);

  // R3: a write cycle never carries an empty lane mask
  a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> (mask_q != '0));

endmodule

// File: tb/tb_sync_sram_core.sv
`timescale 1ns/1ps
module tb_sync_sram_core;

  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          gwr_n, bwr_n;
  logic [3:0]    lane_n;
  logic          pipe_mode, out_en_n, sleep;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  logic [DW-1:0] model [1<<AW];

  sync_sram_core #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
    .pipe_mode(pipe_mode), .out_en_n(out_en_n), .sleep(sleep),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
  endtask

  task automatic drive(input int a, input logic [DW-1:0] d,
                       input logic g_n, input logic b_n, input logic [3:0] ln);
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    addr = AW'(a); wr_data = d; gwr_n = g_n; bwr_n = b_n; lane_n = ln;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] d,
                                          input logic g_n, input logic b_n, input logic [3:0] ln);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < 4; i++)
      if (!g_n || (!b_n && !ln[i])) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d,
                    input logic g_n, input logic b_n, input logic [3:0] ln);
    drive(a, d, g_n, b_n, ln);
    step();
    idle();
    step();
    model[a] = merge(model[a], d, g_n, b_n, ln);
  endtask

  task automatic read_ft(input int a, input string req);
    pipe_mode = 1'b0;
    drive(a, '0, 1'b1, 1'b1, 4'hF);
    step();
    chk({req, " flow valid"}, {31'd0, rd_valid}, 1);
    chk({req, " flow data"}, rd_data, model[a]);
    idle();
    step();
    chk("R10 flow off after deselect", {31'd0, rd_valid}, 0);
  endtask

  task automatic read_pl(input int a, input string req);
    pipe_mode = 1'b1;
    drive(a, '0, 1'b1, 1'b1, 4'hF);
    step();
    chk("R6 pipe not yet valid", {31'd0, rd_valid}, 0);
    idle();
    step();
    chk({req, " pipe valid"}, {31'd0, rd_valid}, 1);
    chk({req, " pipe data"}, rd_data, model[a]);
    step();
    chk("R10 pipe off one cycle later", {31'd0, rd_valid}, 0);
    pipe_mode = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", {31'd0, rd_valid}, 0);
    chk("R1 data after reset", rd_data, 0);
  endtask

  task automatic t_global();
    wr(3, 32'hA5A5_5A5A, 1'b0, 1'b1, 4'hF);
    read_ft(3, "R2 R5");
    wr(3, 32'h0F1E_2D3C, 1'b0, 1'b0, 4'b1110);
    read_ft(3, "R2 lanes ignored");
  endtask

  task automatic t_bytes();
    wr(5, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
    wr(5, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
    chk("R3 model merge", model[5], 32'h11BB_33DD);
    read_ft(5, "R3 partial");
    wr(5, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);
    read_ft(5, "R3 both strobes off");
    wr(5, 32'hEEEE_EEEE, 1'b1, 1'b0, 4'hF);
    read_ft(5, "R3 empty lane mask");
  endtask

  task automatic t_pipe();
    read_pl(3, "R6");
    read_pl(5, "R6 second word");
  endtask

  task automatic t_pass(input logic pm);
    int a = 12;
    wr(a, 32'h0102_0304, 1'b0, 1'b1, 4'hF);
    pipe_mode = pm;
    drive(a, 32'hC0DE_BEEF, 1'b1, 1'b0, 4'b0110);
    step();
    model[a] = merge(model[a], 32'hC0DE_BEEF, 1'b1, 1'b0, 4'b0110);
    drive(a, '0, 1'b1, 1'b1, 4'hF);
    step();
    if (!pm) begin
      chk("R7 flow pass valid", {31'd0, rd_valid}, 1);
      chk("R7 flow pass data", rd_data, 32'hC002_03EF);
      idle();
      step();
    end else begin
      chk("R7 pipe write cycle off", {31'd0, rd_valid}, 0);
      idle();
      step();
      chk("R7 pipe pass valid", {31'd0, rd_valid}, 1);
      chk("R7 pipe pass data", rd_data, 32'hC002_03EF);
    end
    pipe_mode = 1'b0;
    step();
  endtask

  task automatic t_enables();
    wr(9, 32'h5555_AAAA, 1'b0, 1'b1, 4'hF);
    for (int i = 0; i < 3; i++) begin
      drive(9, 32'h1234_5678, 1'b0, 1'b1, 4'hF);
      if (i == 0) sel_a_n = 1'b1;
      if (i == 1) sel_b = 1'b0;
      if (i == 2) sel_c_n = 1'b1;
      step();
      idle();
      step();
      read_ft(9, "R4 write blocked");
      pipe_mode = 1'b0;
      drive(9, '0, 1'b1, 1'b1, 4'hF);
      if (i == 0) sel_a_n = 1'b1;
      if (i == 1) sel_b = 1'b0;
      if (i == 2) sel_c_n = 1'b1;
      step();
      chk("R4 read blocked", {31'd0, rd_valid}, 0);
      idle();
      step();
    end
  endtask

  task automatic t_oe();
    pipe_mode = 1'b0;
    drive(3, '0, 1'b1, 1'b1, 4'hF);
    step();
    #1 out_en_n = 1'b1;
    #0.5;
    chk("R8 oe off valid", {31'd0, rd_valid}, 0);
    chk("R8 oe off data", rd_data, 0);
    out_en_n = 1'b0;
    #0.5;
    chk("R8 oe restored", rd_data, model[3]);
    idle();
    step();
  endtask

  task automatic t_sleep();
    sleep = 1'b1;
    drive(9, 32'hDEAD_0000, 1'b0, 1'b1, 4'hF);
    step();
    sleep = 1'b0;
    idle();
    step();
    read_ft(9, "R9 write while asleep");
    drive(9, '0, 1'b1, 1'b1, 4'hF);
    step();
    #1 sleep = 1'b1;
    #0.5;
    chk("R9 sleep gates output", {31'd0, rd_valid}, 0);
    sleep = 1'b0;
    #0.5;
    chk("R9 output back after sleep", rd_data, model[9]);
    idle();
    step();
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    addr = '0; wr_data = '0;
    pipe_mode = 1'b0; out_en_n = 1'b0; sleep = 1'b0;
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_global();
    t_bytes();
    t_pipe();
    t_pass(1'b0);
    t_pass(1'b1);
    t_enables();
    t_oe();
    t_sleep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule